// File: doc/BRIEF.md
# Key-Locked Flash Control Register

This block is the control register of one flash bank, placed on a simple write bus. It holds the fields an erase/program engine consumes: program enable, sector erase, bank erase, force-write, start, a 7-bit sector number, a CRC enable and eleven interrupt enables. It also decodes these fields into a single operation code for the engine, and it takes acknowledge pulses back from that engine.

A lock guards every field. The lock is set at reset. It opens only after two words are written, one after the other, to a separate key address: first 0x45670123, then 0xCDEF89AB. Two things jam the lock until the next reset: a wrong word at either step, or any key write while the register is already open. Software can close the lock again by writing 1 to the lock bit. That write leaves every other field as it was, and a fresh key sequence then opens the lock again.

While start is pending, a busy output stays high so that the surrounding bus logic can stall. When CRC is disabled, the CRC data seen by software is forced to zero, and the engine gets a one-cycle pulse telling it to drop its CRC configuration.

Top module: `flash_ctl_reg`

## Requirements
- R1: After reset `locked`=1, `busy`=0, `op_kind`=0, `op_sector`=0, `irq_en`=0, `prog_en`=`force_wr`=`crc_en`=0, and `crc_data_out`=0.
- R2: A write of 0x45670123 to the key address (1), followed by the next key-address write carrying 0xCDEF89AB, clears `locked`. Writes to the control address (0) between the two key writes do not break the sequence.
- R3: Three cases jam the lock until reset: a wrong word as the first key write, a wrong word as the second key write, or any key write while unlocked. Any key write while unlocked also sets `locked`=1 at once. Once jammed, later correct sequences leave `locked`=1, and a reset clears the jam.
- R4: While `locked`=1, writes to the control address change no field.
- R5: Two rules cover an unlocked control write with bit 0 (lock) = 1. First, it sets `locked`=1 and leaves every other field unchanged. Second, a later correct key sequence clears `locked` again, and the fields are still retained.
- R6: An unlocked control write with bit 0 = 0 loads all fields from the write data. Bit 1 is program enable, bit 2 sector erase, bit 3 bank erase, bit 4 force-write, bit 5 start, bit 6 CRC enable, bits 14:8 the sector number, and bits 26:16 `irq_en[10:0]`.
- R7: `op_kind` is 3 (bank erase) when bank erase is set, whatever the other bits are. Otherwise it is 2 (sector erase) when sector erase is set, otherwise 1 (program) when program enable is set, otherwise 0.
- R8: `op_sector` equals the sector field when `op_kind`=2, and is 0 otherwise.
- R9: Start and force-write are set by writing 1. Writing 0 leaves them unchanged. They clear only on `start_ack` and `fw_ack`, respectively, one edge after the pulse. `busy` equals the pending start.
- R10: `crc_data_out` equals `crc_data_in` while `crc_en`=1 and is 0 otherwise. `crc_clear` is high for exactly the one cycle after `crc_en` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 4 | Write address: 0 control, 1 key |
| wr_data | input | 32 | Write data |
| start_ack | input | 1 | Engine accepted the erase start |
| fw_ack | input | 1 | Engine accepted the forced write |
| crc_data_in | input | 32 | CRC result from the CRC engine |
| locked | output | 1 | Lock state |
| busy | output | 1 | Start pending, not yet acknowledged |
| prog_en | output | 1 | Program buffer enable |
| force_wr | output | 1 | Force-write request |
| op_kind | output | 2 | Decoded operation: 0 none, 1 program, 2 sector erase, 3 bank erase |
| op_sector | output | 7 | Target sector for a sector erase |
| crc_en | output | 1 | CRC enable |
| crc_clear | output | 1 | One-cycle pulse after CRC disable |
| crc_data_out | output | 32 | Gated CRC result |
| irq_en | output | 11 | Interrupt enables |

## Verification
The decode is swept over all eight combinations of the three request bits, paired with sector values 0, 1, 37 and 127. This separates bank-over-sector priority from sector-over-program priority, and shows that the sector number is passed only for a sector erase. The lock is tried with four different wrong first words, a wrong second word, and a repeated unlock while open; each case is followed by a correct sequence, which tells a jammed lock apart from a merely closed one. A walking one across the interrupt enables checks field placement. A re-lock write with changed data, followed by a reopen, shows that a lock-setting write freezes the other fields.

// File: rtl/flash_ctl_reg.sv
module flash_ctl_reg #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int SEC_W  = 7,
  parameter int IRQ_N  = 11,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 4'h0,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 4'h1,
  parameter logic [DATA_W-1:0] KEY1 = 32'h45670123,
  parameter logic [DATA_W-1:0] KEY2 = 32'hCDEF89AB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              start_ack,
  input  logic              fw_ack,
  input  logic [DATA_W-1:0] crc_data_in,
  output logic              locked,
  output logic              busy,
  output logic              prog_en,
  output logic              force_wr,
  output logic [1:0]        op_kind,
  output logic [SEC_W-1:0]  op_sector,
  output logic              crc_en,
  output logic              crc_clear,
  output logic [DATA_W-1:0] crc_data_out,
  output logic [IRQ_N-1:0]  irq_en
);
  localparam int B_LOCK = 0;
  localparam int B_PROG = 1;
  localparam int B_SER  = 2;
  localparam int B_BER  = 3;
  localparam int B_FW   = 4;
  localparam int B_GO   = 5;
  localparam int B_CRC  = 6;
  localparam int SEC_LSB = 8;
  localparam int IRQ_LSB = 16;

  logic lock_q, jam_q, half_q;
  logic prog_q, ser_q, ber_q, fw_q, go_q, crc_q, crc_d1;
  logic [SEC_W-1:0] sec_q;
  logic [IRQ_N-1:0] irq_q;

  logic ctrl_wr, key_wr, open_wr, load;
  assign ctrl_wr = wr_en && (wr_addr == CTRL_ADDR);
  assign key_wr  = wr_en && (wr_addr == KEY_ADDR);
  assign open_wr = ctrl_wr && !lock_q;
  assign load    = open_wr && !wr_data[B_LOCK];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b1;
      jam_q  <= 1'b0;
      half_q <= 1'b0;
    end else if (key_wr && !jam_q) begin
      if (!lock_q) begin
        jam_q  <= 1'b1;
        lock_q <= 1'b1;
        half_q <= 1'b0;
      end else if (!half_q) begin
        if (wr_data == KEY1) half_q <= 1'b1;
        else                 jam_q  <= 1'b1;
      end else begin
        half_q <= 1'b0;
        if (wr_data == KEY2) lock_q <= 1'b0;
        else                 jam_q  <= 1'b1;
      end
    end else if (open_wr && wr_data[B_LOCK]) begin
      lock_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q <= 1'b0;
      ser_q  <= 1'b0;
      ber_q  <= 1'b0;
      crc_q  <= 1'b0;
      sec_q  <= '0;
      irq_q  <= '0;
    end else if (load) begin
      prog_q <= wr_data[B_PROG];
      ser_q  <= wr_data[B_SER];
      ber_q  <= wr_data[B_BER];
      crc_q  <= wr_data[B_CRC];
      sec_q  <= wr_data[SEC_LSB +: SEC_W];
      irq_q  <= wr_data[IRQ_LSB +: IRQ_N];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q   <= 1'b0;
      fw_q   <= 1'b0;
      crc_d1 <= 1'b0;
    end else begin
      go_q   <= (load && wr_data[B_GO]) || (go_q && !start_ack);
      fw_q   <= (load && wr_data[B_FW]) || (fw_q && !fw_ack);
      crc_d1 <= crc_q;
    end
  end

  assign locked       = lock_q;
  assign busy         = go_q;
  assign prog_en      = prog_q;
  assign force_wr     = fw_q;
  assign crc_en       = crc_q;
  assign irq_en       = irq_q;
  assign crc_clear    = crc_d1 && !crc_q;
  assign crc_data_out = crc_q ? crc_data_in : '0;
  assign op_kind      = ber_q ? 2'd3 : ser_q ? 2'd2 : prog_q ? 2'd1 : 2'd0;
  assign op_sector    = (!ber_q && ser_q) ? sec_q : '0;

  assert_unlock_needs_key2_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_q) |-> $past(key_wr && wr_data == KEY2));
  assert_jam_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    jam_q |=> (jam_q && lock_q));
  assert_locked_write_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && lock_q) |=> ($stable(irq_q) && $stable(sec_q) && $stable(prog_q)
                             && $stable(ser_q) && $stable(ber_q) && $stable(crc_q)));
  assert_relock_freezes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (open_wr && wr_data[B_LOCK]) |=> (lock_q && $stable(irq_q) && $stable(sec_q)
                                      && $stable(ser_q) && $stable(ber_q) && $stable(crc_q)));
  assert_ack_clears_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ack && !(load && wr_data[B_GO])) |=> !go_q);
  assert_crc_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
    crc_clear |-> (crc_data_out == '0));
endmodule

// File: tb/flash_ctl_reg_bench.sv
`timescale 1ns/1ps
module flash_ctl_reg_bench;
  localparam logic [31:0] K1 = 32'h45670123;
  localparam logic [31:0] K2 = 32'hCDEF89AB;

  logic clk = 0, rst_n = 0, wr_en = 0, start_ack = 0, fw_ack = 0;
  logic [3:0] wr_addr = 0;
  logic [31:0] wr_data = 0, crc_data_in = 32'h5A5A_1234;
  logic locked, busy, prog_en, force_wr, crc_en, crc_clear;
  logic [1:0] op_kind;
  logic [6:0] op_sector;
  logic [31:0] crc_data_out;
  logic [10:0] irq_en;
  int vecs = 0, bad = 0;

  always #2.5 clk = ~clk;

  flash_ctl_reg u_flash_ctl_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .start_ack(start_ack), .fw_ack(fw_ack), .crc_data_in(crc_data_in),
    .locked(locked), .busy(busy), .prog_en(prog_en), .force_wr(force_wr),
    .op_kind(op_kind), .op_sector(op_sector), .crc_en(crc_en), .crc_clear(crc_clear),
    .crc_data_out(crc_data_out), .irq_en(irq_en));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    vecs++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic unlock();
    wr(4'h1, K1);
    wr(4'h1, K2);
  endtask

  function automatic logic [31:0] mk(input bit lk, input bit pe, input bit se, input bit be,
                                      input bit fw, input bit go, input bit ce,
                                      input int sec, input int irq);
    return {5'd0, irq[10:0], 1'b0, sec[6:0], 1'b0, ce, go, fw, be, se, pe, lk};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    int secs[4] = '{0, 1, 37, 127};
    logic [31:0] wrong[4] = '{K2, K1 ^ 32'h1, 32'h0, 32'hFFFFFFFF};
    do_reset();
    chk("R1 locked", locked, 1);
    chk("R1 busy", busy, 0);
    chk("R1 op_kind", op_kind, 0);
    chk("R1 op_sector", op_sector, 0);
    chk("R1 irq_en", irq_en, 0);
    chk("R1 flags", {prog_en, force_wr, crc_en}, 0);
    chk("R1 crc_data_out", crc_data_out, 0);

    wr(4'h0, 32'hFFFF_FFFE);
    chk("R4 locked write irq", irq_en, 0);
    chk("R4 locked write flags", {prog_en, force_wr, busy, crc_en, op_kind}, 0);

    wr(4'h1, K1);
    wr(4'h0, mk(0, 1, 0, 0, 0, 0, 0, 0, 0));
    chk("R4 write mid-sequence ignored", prog_en, 0);
    wr(4'h1, K2);
    chk("R2 unlocked", locked, 0);

    for (int m = 0; m < 8; m++)
      for (int s = 0; s < 4; s++) begin
        int ek, es;
        wr(4'h0, mk(0, m[0], m[1], m[2], 0, 0, 0, secs[s], 0));
        ek = m[2] ? 3 : m[1] ? 2 : m[0] ? 1 : 0;
        es = (ek == 2) ? secs[s] : 0;
        chk("R7 op_kind", op_kind, ek);
        chk("R8 op_sector", op_sector, es);
        chk("R6 prog_en", prog_en, m[0]);
      end

    for (int i = 0; i < 11; i++) begin
      wr(4'h0, mk(0, 0, 0, 0, 0, 0, 0, 0, 1 << i));
      chk("R6 irq walk", irq_en, 1 << i);
    end

    wr(4'h0, mk(0, 0, 1, 0, 0, 1, 0, 3, 0));
    chk("R9 busy set", busy, 1);
    wr(4'h0, mk(0, 0, 1, 0, 0, 0, 0, 3, 0));
    chk("R9 write 0 keeps start", busy, 1);
    @(negedge clk); start_ack = 1;
    @(negedge clk); start_ack = 0;
    chk("R9 start_ack clears", busy, 0);
    wr(4'h0, mk(0, 1, 0, 0, 1, 0, 0, 0, 0));
    chk("R9 force set", force_wr, 1);
    @(negedge clk); fw_ack = 1;
    @(negedge clk); fw_ack = 0;
    chk("R9 fw_ack clears", force_wr, 0);

    wr(4'h0, mk(0, 0, 0, 0, 0, 0, 1, 0, 0));
    chk("R10 crc pass", crc_data_out, 32'h5A5A_1234);
    chk("R10 no clear while on", crc_clear, 0);
    wr(4'h0, mk(0, 0, 0, 0, 0, 0, 0, 0, 0));
    chk("R10 crc zero", crc_data_out, 0);
    chk("R10 clear pulse", crc_clear, 1);
    @(negedge clk);
    chk("R10 clear one cycle", crc_clear, 0);

    wr(4'h0, mk(0, 0, 1, 0, 0, 0, 1, 5, 11'h155));
    wr(4'h0, mk(1, 1, 0, 1, 0, 0, 0, 9, 11'h2AA));
    chk("R5 relocked", locked, 1);
    chk("R5 irq frozen", irq_en, 11'h155);
    chk("R5 op frozen", {op_kind, op_sector}, {2'd2, 7'd5});
    chk("R5 crc frozen", crc_en, 1);
    wr(4'h0, mk(0, 0, 0, 0, 0, 0, 0, 0, 0));
    chk("R4 locked after relock", irq_en, 11'h155);
    unlock();
    chk("R5 reopen", locked, 0);
    chk("R5 fields kept", irq_en, 11'h155);

    wr(4'h1, K1);
    chk("R3 key while open locks", locked, 1);
    unlock();
    chk("R3 jammed after repeat", locked, 1);
    do_reset();
    unlock();
    chk("R3 reset clears jam", locked, 0);

    for (int w = 0; w < 4; w++) begin
      do_reset();
      wr(4'h1, wrong[w]);
      unlock();
      chk("R3 wrong first word", locked, 1);
    end
    do_reset();
    wr(4'h1, K1);
    wr(4'h1, K1);
    unlock();
    chk("R3 wrong second word", locked, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule